// File: doc/BRIEF.md
# SPI Master Controller with FIFO Status

This block is a CPU-programmed SPI master. Software sets it up through a small word-addressed register bus. It loads transmit units into a 64-entry transmit FIFO and takes received units out of a 64-entry receive FIFO. A shift engine drives SCLK and MOSI in SPI mode 0, MSB first, and samples MISO on each rising SCLK edge. The chip-select pin is active low and software drives it directly.

A single status word reports:
- whether the transmit FIFO can take data;
- whether the receive FIFO holds data;
- the fill levels of both FIFOs;
- four sticky error flags.

Each error flag is cleared by writing 1 to its bit in a separate clear register. An interrupt output is the OR of the enabled status sources. A packet counter lets the master clock in a programmed number of receive units with no transmit data. Each transfer unit is a byte, a halfword or a word. Each data-register access pushes or pops exactly one unit, LSB-aligned in the 32-bit data word.

Register map (word addresses):
- 0 config: bit 0 transmit enable, bit 1 receive enable, bits 3:2 unit size (0 byte, 1 halfword, 2 word).
- 1 clock: bit 8 SCLK enable.
- 2 select: bit 0 chip-select level.
- 3 interrupt enable.
- 4 status (read only).
- 5 flag clear.
- 6 transmit data.
- 7 receive data.
- 8 packet: bit 16 enable, bits 15:0 unit count.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, irq_o is 0, and status reads 0x00000001 (transmit FIFO ready, everything else clear).
- R2: Status bit 0 is 1 when the transmit FIFO is not full. Bit 1 is 1 when the receive FIFO is not empty. Bits 12:6 hold the transmit fill level and bits 19:13 hold the receive fill level, each as a 7-bit count.
- R3: A write to the transmit data register while the transmit FIFO holds 64 units is dropped, and status bit 4 (transmit overrun) is set.
- R4: A read of the receive data register while the receive FIFO is empty returns 0 and sets status bit 3 (receive underrun).
- R5: Status bits 2..5 stay set until a write to the clear register with 1 in the same bit position. A 0 in that position leaves the flag unchanged.
- R6: SCLK idles low with a period of CLK_DIV system clocks. Each unit is shifted MSB first over 8, 16 or 32 SCLK cycles, per config bits 3:2. With MISO looped to MOSI, each received unit equals the transmitted unit masked to its size.
- R7: cs_no follows bit 0 of the last value written to the select register.
- R8: While clock bit 8 is 0, no new unit starts and the transmit FIFO keeps its contents.
- R9: With packet bit 16 set and a count N in bits 15:0, and receive enabled with transmit disabled, the master clocks exactly N units into the receive FIFO and then stops.
- R10: When a unit starts in packet mode with transmit enabled and the transmit FIFO empty, status bit 5 (transmit underrun) is set and zeros are shifted out.
- R11: A unit that completes while the receive FIFO holds 64 units is dropped, and status bit 2 (receive overrun) is set.
- R12: irq_o is 1 exactly when some status bit 0..5 is set while the same bit of the interrupt-enable register is set.
- R13: With receive disabled, shifted units are not stored in the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request, one access per cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 4 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read request |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle:
- neither FIFO is pushed when full, and neither fill level exceeds the depth;
- SCLK stays low whenever no unit is in flight;
- a running unit never counts past its size;
- no unit starts while SCLK generation is off;
- chip select tracks the last select write;
- the packet counter never wraps;
- overrun flags persist until an explicit clear.

Only the bench scenarios can show that shifted data arrives intact and MSB first for each unit size, and that the SCLK period is right. They also show that a programmed packet count yields exactly that many units, and that each error flag is raised by its triggering access. The interrupt output's mapping from enabled sources is likewise checked only by the scenarios.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 32;
  localparam int NB_W   = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } unit_sz_e;

  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_CLK  = 4'd1;
  localparam logic [3:0] A_SEL  = 4'd2;
  localparam logic [3:0] A_IEN  = 4'd3;
  localparam logic [3:0] A_STAT = 4'd4;
  localparam logic [3:0] A_CLR  = 4'd5;
  localparam logic [3:0] A_TXD  = 4'd6;
  localparam logic [3:0] A_RXD  = 4'd7;
  localparam logic [3:0] A_PKT  = 4'd8;

  function automatic logic [NB_W-1:0] unit_bits(logic [1:0] sz);
    case (sz)
      SZ_BYTE: unit_bits = NB_W'(8);
      SZ_HALF: unit_bits = NB_W'(16);
      default: unit_bits = NB_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW      = 32,
  parameter int CLK_DIV = 4,
  localparam int HALF   = CLK_DIV / 2,
  localparam int CW     = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int NBW    = $clog2(DW + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [DW-1:0]  tx_word_i,
  input  logic [NBW-1:0] nbits_i,
  input  logic           miso_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  rx_word_o,
  output logic           sclk_o,
  output logic           mosi_o
);
  logic           busy_q, sclk_q;
  logic [CW-1:0]  div_q;
  logic [NBW-1:0] bit_q, nb_q;
  logic [DW-1:0]  tsh_q, rsh_q;
  logic           tick;

  assign tick      = busy_q && (div_q == CW'(HALF - 1));
  assign done_o    = tick && sclk_q && (bit_q == nb_q - 1'b1);
  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tsh_q[DW-1];
  assign rx_word_o = rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= nbits_i;
      tsh_q  <= tx_word_i << (NBW'(DW) - nbits_i);  // MSB of unit to top
      rsh_q  <= '0;
    end else if (busy_q) begin
      if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          rsh_q <= {rsh_q[DW-2:0], miso_i};
        end else begin
          tsh_q <= tsh_q << 1;
          bit_q <= bit_q + 1'b1;
          if (bit_q == nb_q - 1'b1) busy_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  p_sclk_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  p_bit_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_q < nb_q));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CLK_DIV    = 4,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no,
  output logic        irq_o
);
  logic       tx_en_q, rx_en_q, sclk_en_q, cs_q, pkt_en_q;
  logic [1:0] sz_q;
  logic [5:0] ien_q;
  logic [15:0] pkt_left_q;
  logic [3:0] err_q;  // 0 rx_ovr, 1 rx_udr, 2 tx_ovr, 3 tx_udr

  logic wr, rd;
  logic tx_wr, tx_push, tx_pop, tx_full, tx_empty;
  logic rx_rd, rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_rdata, rx_rdata, tx_word, rx_word;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic busy, done, start, tx_go, pkt_go;
  logic [3:0] err_set, err_clr;
  logic [31:0] status;
  logic unused_bits;

  assign unused_bits = ^wdata_i;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign tx_wr = wr && (addr_i == A_TXD);
  assign rx_rd = rd && (addr_i == A_RXD);

  assign tx_push = tx_wr && !tx_full;
  assign rx_pop  = rx_rd && !rx_empty;

  assign tx_go  = tx_en_q && !tx_empty;
  assign pkt_go = rx_en_q && pkt_en_q && (pkt_left_q != 16'd0);
  assign start  = sclk_en_q && !busy && (tx_go || pkt_go);
  assign tx_pop = start && tx_en_q && !tx_empty;
  assign tx_word = tx_pop ? tx_rdata : '0;

  assign rx_push = done && rx_en_q && !rx_full;

  assign err_set = {start && tx_en_q && tx_empty,
                    tx_wr && tx_full,
                    rx_rd && rx_empty,
                    done && rx_en_q && rx_full};
  assign err_clr = (wr && addr_i == A_CLR) ? wdata_i[5:2] : 4'b0;

  assign status = {12'b0, 7'(rx_lvl), 7'(tx_lvl), err_q, !rx_empty, !tx_full};
  assign irq_o  = |(ien_q & status[5:0]);
  assign cs_no  = cs_q;

  spim_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i), .pop_i(tx_pop), .rdata_o(tx_rdata),
    .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_lvl)
  );

  spim_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_word), .pop_i(rx_pop), .rdata_o(rx_rdata),
    .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_lvl)
  );

  spim_shift #(.DW(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start), .tx_word_i(tx_word), .nbits_i(unit_bits(sz_q)),
    .miso_i(miso_i), .busy_o(busy), .done_o(done), .rx_word_o(rx_word),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q    <= 1'b0;
      rx_en_q    <= 1'b0;
      sz_q       <= SZ_BYTE;
      sclk_en_q  <= 1'b0;
      cs_q       <= 1'b1;
      ien_q      <= '0;
      pkt_en_q   <= 1'b0;
      pkt_left_q <= '0;
      err_q      <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;  // set wins
      if (start && pkt_en_q && pkt_left_q != 16'd0) pkt_left_q <= pkt_left_q - 1'b1;
      if (wr) begin
        case (addr_i)
          A_CFG: begin
            tx_en_q <= wdata_i[0];
            rx_en_q <= wdata_i[1];
            sz_q    <= wdata_i[3:2];
          end
          A_CLK: sclk_en_q <= wdata_i[8];
          A_SEL: cs_q      <= wdata_i[0];
          A_IEN: ien_q     <= wdata_i[5:0];
          A_PKT: begin
            pkt_en_q   <= wdata_i[16];
            pkt_left_q <= wdata_i[15:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        A_CFG:  rdata_o = {28'b0, sz_q, rx_en_q, tx_en_q};
        A_CLK:  rdata_o = {23'b0, sclk_en_q, 8'b0};
        A_SEL:  rdata_o = {31'b0, cs_q};
        A_IEN:  rdata_o = {26'b0, ien_q};
        A_STAT: rdata_o = status;
        A_RXD:  rdata_o = rx_empty ? '0 : rx_rdata;
        A_PKT:  rdata_o = {15'b0, pkt_en_q, pkt_left_q};
        default: rdata_o = '0;
      endcase
    end
  end

  p_cs_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_SEL) |=> (cs_no == $past(wdata_i[0])));
  p_gated_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !sclk_en_q) |=> !busy);
  p_pkt_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_left_q == 16'd0 && !(wr && addr_i == A_PKT)) |=> (pkt_left_q == 16'd0));
  p_tx_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[2] && !(wr && addr_i == A_CLR && wdata_i[4])) |=> err_q[2]);
  p_rx_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[0] && !(wr && addr_i == A_CLR && wdata_i[2])) |=> err_q[0]);
endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
  localparam int DIV = 4;
  localparam logic [3:0] CFG = 0, CLK = 1, SEL = 2, IEN = 3, STAT = 4, CLR = 5,
                         TXD = 6, RXD = 7, PKT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, cs_n, irq;
  logic loop_en = 1'b1, miso_drv = 1'b0;
  logic miso;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign miso = loop_en ? mosi : miso_drv;

  spi_fifo_master uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  // SCLK monitor: bits seen at rising edges, rise count, shortest period
  logic [31:0] mon_bits = '0;
  int mon_cnt = 0;
  longint last_rise = -1, min_per = 1000000;
  always @(posedge sclk) begin
    mon_bits <= {mon_bits[30:0], mosi};
    mon_cnt  <= mon_cnt + 1;
    if (last_rise >= 0 && ($time - last_rise) < min_per) min_per = $time - last_rise;
    last_rise = $time;
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  function automatic logic [31:0] sz_mask(int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic wait_lvl(bit rx, int n);
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      rd(STAT, s);
      if ((rx ? s[19:13] : s[12:6]) == 7'(n)) break;
    end
  endtask

  initial begin
    #(100000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    logic [31:0] exp_q [$];
    int c0;
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    check("R1 cs_no", 32'(cs_n), 1);
    check("R1 sclk", 32'(sclk), 0);
    check("R1 irq", 32'(irq), 0);
    rd(STAT, s); check("R1 status", s, 32'h1);

    // R7 chip select
    wr(SEL, 0); check("R7 cs low", 32'(cs_n), 0);
    wr(SEL, 1); check("R7 cs high", 32'(cs_n), 1);
    wr(SEL, 0);

    // R8 gating: tx on, byte, clocks off
    wr(CFG, 32'h1);
    wr(TXD, 32'h0000_12A5);
    c0 = mon_cnt;
    repeat (100) @(posedge clk);
    rd(STAT, s);
    check("R8 tx level held", 32'(s[12:6]), 1);
    check("R8 no clocks", mon_cnt, c0);

    // R6 MSB first byte, period; R13 rx disabled
    wr(CLK, 32'h100);
    wait_lvl(0, 0);
    repeat (60) @(posedge clk);
    check("R6 eight clocks", mon_cnt - c0, 8);
    check("R6 msb first bits", 32'(mon_bits[7:0]), 32'hA5);
    check("R6 sclk period", 32'(min_per), DIV * 4);
    rd(STAT, s);
    check("R13 rx not stored", 32'(s[19:13]), 0);
    c0 = mon_cnt;
    repeat (80) @(posedge clk);
    check("R6 stops when empty", mon_cnt, c0);

    // R2/R6 random loopback per unit size
    for (int sz = 0; sz < 3; sz++) begin
      wr(CLK, 0);
      wr(CFG, 32'(3 | (sz << 2)));
      exp_q.delete();
      for (int k = 0; k < 5; k++) begin
        d = $urandom;
        exp_q.push_back(d & sz_mask(sz));
        wr(TXD, d);
      end
      rd(STAT, s);
      check("R2 tx level", 32'(s[12:6]), 5);
      check("R2 rx empty bit", 32'(s[1]), 0);
      check("R2 tx ready bit", 32'(s[0]), 1);
      wr(CLK, 32'h100);
      wait_lvl(1, 5);
      rd(STAT, s);
      check("R2 rx level", 32'(s[19:13]), 5);
      check("R2 rx data bit", 32'(s[1]), 1);
      for (int k = 0; k < 5; k++) begin
        rd(RXD, d);
        check("R6 loopback unit", d, exp_q[k]);
      end
    end

    // R3 tx overrun, R12 irq, R5 clear
    wr(CLK, 0);
    wr(CFG, 32'h1);
    for (int k = 0; k < 65; k++) wr(TXD, 32'(k));
    rd(STAT, s);
    check("R3 tx level full", 32'(s[12:6]), 64);
    check("R3 tx ready low", 32'(s[0]), 0);
    check("R3 tx overrun", 32'(s[4]), 1);
    check("R12 irq masked", 32'(irq), 0);
    wr(IEN, 32'h10);
    check("R12 irq enabled", 32'(irq), 1);
    wr(CLR, 32'h0);
    rd(STAT, s); check("R5 zero keeps flag", 32'(s[4]), 1);
    wr(CLR, 32'h10);
    rd(STAT, s); check("R5 one clears flag", 32'(s[4]), 0);
    check("R12 irq dropped", 32'(irq), 0);
    wr(IEN, 0);
    wr(CLK, 32'h100);
    wait_lvl(0, 0);
    repeat (60) @(posedge clk);

    // R4 rx underrun
    rd(RXD, d);
    check("R4 empty pop zero", d, 0);
    rd(STAT, s); check("R4 rx underrun", 32'(s[3]), 1);
    wr(CLR, 32'h3C);

    // R9 packet receive-only
    loop_en = 0; miso_drv = 1;
    wr(CFG, 32'h2);
    c0 = mon_cnt;
    wr(PKT, 32'h0001_000A);
    wait_lvl(1, 10);
    repeat (100) @(posedge clk);
    rd(STAT, s);
    check("R9 unit count", 32'(s[19:13]), 10);
    check("R9 clocks", mon_cnt - c0, 80);
    for (int k = 0; k < 10; k++) begin
      rd(RXD, d);
      check("R9 rx data", d, 32'hFF);
    end

    // R10 tx underrun in packet mode
    loop_en = 1;
    wr(CFG, 32'h3);
    wr(PKT, 32'h0001_0002);
    wait_lvl(1, 2);
    rd(STAT, s);
    check("R10 tx underrun", 32'(s[5]), 1);
    rd(RXD, d); check("R10 zeros shifted", d, 0);
    rd(RXD, d); check("R10 zeros shifted", d, 0);
    wr(CLR, 32'h3C);

    // R11 rx overrun
    loop_en = 0;
    wr(CFG, 32'h2);
    wr(PKT, 32'h0001_0042);
    wait_lvl(1, 64);
    repeat (200) @(posedge clk);
    rd(STAT, s);
    check("R11 rx level", 32'(s[19:13]), 64);
    check("R11 rx overrun", 32'(s[2]), 1);
    wr(IEN, 32'h4);
    check("R12 irq rx overrun", 32'(irq), 1);
    wr(IEN, 32'h2);
    check("R12 irq rx ready", 32'(irq), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule